// File: doc/BRIEF.md
# DDR write-to-read turnaround scheduler

This block drives the command and write-data pins of a DDR SDRAM for one short sequence. A WRITE is cut off after its first data pair by a READ to the same bank. The requester presents a write request, which carries the bank, the start column, a full burst of data elements and a per-element byte mask. It then presents a read request, which carries only a column. The scheduler issues WRITE with auto precharge off. It drives the first two data elements in the programmed burst order on the two edges of one clock, with DQS toggling so the memory registers DM. It then counts the write-to-read delay and issues the READ.

Data is modelled per clock. `dq_rise`/`dm_rise` is the beat launched on the rising half and `dq_fall`/`dm_fall` the beat on the falling half. `dqs_tgl` marks a clock in which the strobe toggles, and `dqs_oe` with no toggle marks the preamble. Burst length (4 or 8) and burst order (sequential or interleaved) are sampled with the write request. With burst length 8 the READ itself cuts off the unsent beats. With burst length 4 one further strobed clock carries two fully masked beats. The wait is counted from that last strobed clock.

States: `ST_IDLE` goes to `ST_WRCMD` on an accepted write request. `ST_WRCMD` always goes to `ST_DATA`. `ST_DATA` goes to `ST_TAIL` for burst length 4 or to `ST_WTR` for burst length 8. `ST_TAIL` always goes to `ST_WTR`. `ST_WTR` goes to `ST_RDCMD` once the counter is zero and a read is pending or arriving. `ST_RDCMD` always goes to `ST_IDLE`.

Top module: `wtr_sched`

## Requirements
- R1: During and after reset, with no request, `cmd` is NOP (3'b111), `ready` is 1, and `dq_oe`, `dqs_oe` and `dqs_tgl` are 0.
- R2: A `wr_req` sampled while `ready` is 1 gives in the next clock `cmd` = WRITE (3'b100, the {ras_n,cas_n,we_n} bits), `ba` = `wr_bank`, `addr` = `wr_col` zero-extended with bit 10 (auto precharge) at 0, and `dqs_oe` = 1 with `dqs_tgl` = 0 (preamble). `ready` is 0.
- R3: The clock after WRITE has `cmd` NOP, `dq_oe`, `dqs_oe` and `dqs_tgl` at 1, and `dq_rise`/`dm_rise` equal to the element and mask of the start column. Element i is `wr_data[i*DW +: DW]` and its mask is `wr_mask[i*LANES +: LANES]`, with i the column's low three bits.
- R4: `dq_fall`/`dm_fall` in that clock carry the element of the second column in burst order. Sequential order adds 1 modulo the burst length inside the aligned block of that length. Interleaved order flips column bit 0.
- R5: With burst length 4 (`cfg_bl8` = 0), exactly one more clock follows with the strobe toggling, `dq_oe` = 1, both DM beats all ones and DQ zero.
- R6: With burst length 8 (`cfg_bl8` = 1), no tail clock is sent, and `dqs_oe` and `dq_oe` are 0 in the clock after the data clock.
- R7: Between the last strobed clock and READ there are exactly TWTR clocks when the read was already requested, never fewer. Every clock between WRITE and READ carries NOP.
- R8: READ is `cmd` 3'b101 with `ba` equal to the write bank and `addr` = `rd_col` with bit 10 at 0. It lasts one clock and `ready` is 1 in the next clock.
- R9: A `rd_req` sampled after the wait has expired gives READ in the very next clock.
- R10: `wr_req` while not ready and `rd_req` while ready have no effect: the command stream is unchanged and no READ is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl8 | input | 1 | Burst length 8 when 1, 4 when 0; sampled with write request |
| cfg_ilv | input | 1 | Interleaved burst order when 1, sequential when 0 |
| wr_req | input | 1 | Write request strobe |
| wr_bank | input | BA_W | Target bank |
| wr_col | input | COL_W | Start column of the write |
| wr_data | input | 8*DW | Eight data elements, indexed by column low bits |
| wr_mask | input | 8*LANES | Byte mask per element, 1 = masked |
| rd_req | input | 1 | Read request strobe |
| rd_col | input | COL_W | Column of the read |
| ready | output | 1 | Idle, write request accepted |
| cmd | output | 3 | {ras_n, cas_n, we_n} |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus, bit 10 is auto precharge |
| dq_oe | output | 1 | Data bus driven |
| dq_rise | output | DW | Data beat on the rising half |
| dq_fall | output | DW | Data beat on the falling half |
| dm_rise | output | LANES | Mask beat on the rising half |
| dm_fall | output | LANES | Mask beat on the falling half |
| dqs_oe | output | 1 | Strobe driven (preamble or toggling) |
| dqs_tgl | output | 1 | Strobe toggles in this clock |

## Verification
With a write request taken at edge k, WRITE is on the pins in the clock after k. The data pair follows one clock later, the burst-4 tail one clock after that, and READ comes TWTR+1 clocks after the last strobed clock. A read request that arrives late gives READ in the clock right after the edge that samples it. The bench drives and samples on the falling edge and keeps a cycle index from the accepted write. It compares every output in every clock of the sequence against a timeline built from the burst length and TWTR. The sweep covers both burst lengths, both orders, all eight start offsets and early and late reads.

// File: rtl/wtr_pkg.sv
package wtr_pkg;

    localparam int AP_BIT     = 10;
    localparam int PAIR_BEATS = 2;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'b111,
        CMD_WRITE = 3'b100,
        CMD_READ  = 3'b101
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRCMD,
        ST_DATA,
        ST_TAIL,
        ST_WTR,
        ST_RDCMD
    } state_e;

    // Column low bits of beat k for a burst starting at s.
    function automatic logic [2:0] burst_elem(
        input logic [2:0] s,
        input logic [2:0] k,
        input logic       bl8,
        input logic       ilv
    );
        logic [2:0] r;
        if (ilv) begin
            r = s ^ k;
        end else if (bl8) begin
            r = s + k;
        end else begin
            r = {s[2], s[1:0] + k[1:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/wtr_ctrl.sv
module wtr_ctrl
    import wtr_pkg::*;
#(
    parameter int TWTR = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_req,
    input  logic   rd_req,
    input  logic   bl8_q,
    output state_e state,
    output logic   wr_take,
    output logic   rd_take
);

    localparam int CNT_W = (TWTR > 1) ? $clog2(TWTR) : 1;

    state_e           nxt;
    logic [CNT_W-1:0] cnt;
    logic             rd_pend;
    logic             wait_done;

    assign wr_take   = (state == ST_IDLE) && wr_req;
    assign rd_take   = rd_req && (state != ST_IDLE) && (state != ST_RDCMD);
    assign wait_done = (cnt == '0) && (rd_pend || rd_take);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (wr_take) nxt = ST_WRCMD;
            ST_WRCMD: nxt = ST_DATA;
            ST_DATA:  nxt = bl8_q ? ST_WTR : ST_TAIL;
            ST_TAIL:  nxt = ST_WTR;
            ST_WTR:   if (wait_done) nxt = ST_RDCMD;
            ST_RDCMD: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if ((nxt == ST_WTR) && (state != ST_WTR)) begin
            cnt <= CNT_W'(TWTR - 1);
        end else if ((state == ST_WTR) && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
        end else if (state == ST_RDCMD) begin
            rd_pend <= 1'b0;
        end else if (rd_take) begin
            rd_pend <= 1'b1;
        end
    end

    AST_BL8_SKIPS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bl8_q) |=> (state == ST_WTR)); // R6
    AST_BL4_HAS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !bl8_q) |=> (state == ST_TAIL)); // R5
    AST_IDLE_IGNORES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !wr_req) |=> (state == ST_IDLE)); // R10

endmodule

// File: rtl/wtr_beat_sel.sv
module wtr_beat_sel
    import wtr_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LANES = 1
) (
    input  logic [8*DW-1:0]                     data_q,
    input  logic [8*LANES-1:0]                  mask_q,
    input  logic [2:0]                          start,
    input  logic                                bl8,
    input  logic                                ilv,
    output logic [PAIR_BEATS-1:0][DW-1:0]       d_beat,
    output logic [PAIR_BEATS-1:0][LANES-1:0]    m_beat
);

    for (genvar k = 0; k < PAIR_BEATS; k++) begin : g_beat
        logic [2:0] idx;
        assign idx       = burst_elem(start, 3'(k), bl8, ilv);
        assign d_beat[k] = data_q[int'(idx)*DW +: DW];
        assign m_beat[k] = mask_q[int'(idx)*LANES +: LANES];
    end

endmodule

// File: rtl/wtr_io.sv
module wtr_io
    import wtr_pkg::*;
#(
    parameter int DW     = 8,
    parameter int LANES  = 1,
    parameter int BA_W   = 2,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  state_e                              state,
    input  logic [BA_W-1:0]                     bank_q,
    input  logic [COL_W-1:0]                    wcol_q,
    input  logic [COL_W-1:0]                    rcol_q,
    input  logic [PAIR_BEATS-1:0][DW-1:0]       d_beat,
    input  logic [PAIR_BEATS-1:0][LANES-1:0]    m_beat,
    output logic [2:0]                          cmd,
    output logic [BA_W-1:0]                     ba,
    output logic [ADDR_W-1:0]                   addr,
    output logic                                dq_oe,
    output logic [DW-1:0]                       dq_rise,
    output logic [DW-1:0]                       dq_fall,
    output logic [LANES-1:0]                    dm_rise,
    output logic [LANES-1:0]                    dm_fall,
    output logic                                dqs_oe,
    output logic                                dqs_tgl
);

    cmd_e cmd_v;

    function automatic logic [ADDR_W-1:0] col_addr(input logic [COL_W-1:0] c);
        logic [ADDR_W-1:0] a;
        a             = '0;
        a[COL_W-1:0]  = c;
        a[AP_BIT]     = 1'b0;
        return a;
    endfunction

    always_comb begin
        cmd_v   = CMD_NOP;
        ba      = '0;
        addr    = '0;
        dq_oe   = 1'b0;
        dq_rise = '0;
        dq_fall = '0;
        dm_rise = '0;
        dm_fall = '0;
        dqs_oe  = 1'b0;
        dqs_tgl = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WRCMD: begin
                cmd_v  = CMD_WRITE;
                ba     = bank_q;
                addr   = col_addr(wcol_q);
                dqs_oe = 1'b1;
            end
            ST_DATA: begin
                dq_oe   = 1'b1;
                dqs_oe  = 1'b1;
                dqs_tgl = 1'b1;
                dq_rise = d_beat[0];
                dq_fall = d_beat[1];
                dm_rise = m_beat[0];
                dm_fall = m_beat[1];
            end
            ST_TAIL: begin
                dq_oe   = 1'b1;
                dqs_oe  = 1'b1;
                dqs_tgl = 1'b1;
                dm_rise = '1;
                dm_fall = '1;
            end
            ST_WTR: ;
            ST_RDCMD: begin
                cmd_v = CMD_READ;
                ba    = bank_q;
                addr  = col_addr(rcol_q);
            end
            default: ;
        endcase
    end

    assign cmd = cmd_v;

    AST_AP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v != CMD_NOP) |-> !addr[AP_BIT]); // R2
    AST_DATA_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v == CMD_WRITE) |=> (dqs_tgl && dq_oe)); // R3
    AST_TAIL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dqs_tgl && $past(dqs_tgl)) |-> ((&dm_rise) && (&dm_fall))); // R5
    AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v == CMD_READ) |=> (cmd_v == CMD_NOP)); // R8

endmodule

// File: rtl/wtr_sched.sv
module wtr_sched
    import wtr_pkg::*;
#(
    parameter int DW     = 8,
    parameter int LANES  = 1,
    parameter int BA_W   = 2,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int TWTR   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_bl8,
    input  logic                  cfg_ilv,
    input  logic                  wr_req,
    input  logic [BA_W-1:0]       wr_bank,
    input  logic [COL_W-1:0]      wr_col,
    input  logic [8*DW-1:0]       wr_data,
    input  logic [8*LANES-1:0]    wr_mask,
    input  logic                  rd_req,
    input  logic [COL_W-1:0]      rd_col,
    output logic                  ready,
    output logic [2:0]            cmd,
    output logic [BA_W-1:0]       ba,
    output logic [ADDR_W-1:0]     addr,
    output logic                  dq_oe,
    output logic [DW-1:0]         dq_rise,
    output logic [DW-1:0]         dq_fall,
    output logic [LANES-1:0]      dm_rise,
    output logic [LANES-1:0]      dm_fall,
    output logic                  dqs_oe,
    output logic                  dqs_tgl
);

    localparam int GAP_W = $clog2(TWTR + 2) + 1;

    state_e                            state;
    logic                              wr_take;
    logic                              rd_take;
    logic [BA_W-1:0]                   bank_q;
    logic [COL_W-1:0]                  wcol_q;
    logic [COL_W-1:0]                  rcol_q;
    logic [8*DW-1:0]                   data_q;
    logic [8*LANES-1:0]                mask_q;
    logic                              bl8_q;
    logic                              ilv_q;
    logic [PAIR_BEATS-1:0][DW-1:0]     d_beat;
    logic [PAIR_BEATS-1:0][LANES-1:0]  m_beat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            wcol_q <= '0;
            data_q <= '0;
            mask_q <= '0;
            bl8_q  <= 1'b0;
            ilv_q  <= 1'b0;
        end else if (wr_take) begin
            bank_q <= wr_bank;
            wcol_q <= wr_col;
            data_q <= wr_data;
            mask_q <= wr_mask;
            bl8_q  <= cfg_bl8;
            ilv_q  <= cfg_ilv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcol_q <= '0;
        end else if (rd_take) begin
            rcol_q <= rd_col;
        end
    end

    assign ready = (state == ST_IDLE);

    wtr_ctrl #(.TWTR(TWTR)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .bl8_q   (bl8_q),
        .state   (state),
        .wr_take (wr_take),
        .rd_take (rd_take)
    );

    wtr_beat_sel #(.DW(DW), .LANES(LANES)) u_beat (
        .data_q (data_q),
        .mask_q (mask_q),
        .start  (wcol_q[2:0]),
        .bl8    (bl8_q),
        .ilv    (ilv_q),
        .d_beat (d_beat),
        .m_beat (m_beat)
    );

    wtr_io #(
        .DW(DW), .LANES(LANES), .BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_io (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .bank_q  (bank_q),
        .wcol_q  (wcol_q),
        .rcol_q  (rcol_q),
        .d_beat  (d_beat),
        .m_beat  (m_beat),
        .cmd     (cmd),
        .ba      (ba),
        .addr    (addr),
        .dq_oe   (dq_oe),
        .dq_rise (dq_rise),
        .dq_fall (dq_fall),
        .dm_rise (dm_rise),
        .dm_fall (dm_fall),
        .dqs_oe  (dqs_oe),
        .dqs_tgl (dqs_tgl)
    );

    // Clocks since the last strobed clock, saturating; guards the READ gap.
    logic [GAP_W-1:0] gap;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (dqs_tgl) begin
            gap <= '0;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    AST_WTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'b101) |-> (gap >= GAP_W'(TWTR))); // R7
    AST_NO_STROBE_AT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'b101) |-> (!dqs_oe && !dq_oe)); // R7

endmodule

// File: tb/sim_wtr_sched.sv
`timescale 1ns/1ps
module sim_wtr_sched;

    localparam int DW = 8, LANES = 1, BA_W = 2, COL_W = 10, ADDR_W = 13, TW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, cfg_bl8, cfg_ilv, wr_req, rd_req;
    logic [BA_W-1:0] wr_bank;
    logic [COL_W-1:0] wr_col, rd_col;
    logic [8*DW-1:0] wr_data;
    logic [8*LANES-1:0] wr_mask;
    logic ready, dq_oe, dqs_oe, dqs_tgl;
    logic [2:0] cmd;
    logic [BA_W-1:0] ba;
    logic [ADDR_W-1:0] addr;
    logic [DW-1:0] dq_rise, dq_fall;
    logic [LANES-1:0] dm_rise, dm_fall;

    wtr_sched #(.DW(DW), .LANES(LANES), .BA_W(BA_W), .COL_W(COL_W),
                .ADDR_W(ADDR_W), .TWTR(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bl8(cfg_bl8), .cfg_ilv(cfg_ilv),
        .wr_req(wr_req), .wr_bank(wr_bank), .wr_col(wr_col), .wr_data(wr_data),
        .wr_mask(wr_mask), .rd_req(rd_req), .rd_col(rd_col), .ready(ready),
        .cmd(cmd), .ba(ba), .addr(addr), .dq_oe(dq_oe), .dq_rise(dq_rise),
        .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
        .dqs_oe(dqs_oe), .dqs_tgl(dqs_tgl)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int elem(int s, int k, bit bl8, bit ilv);
        int bl;
        bl = bl8 ? 8 : 4;
        if (ilv) return s ^ k;
        return (s / bl) * bl + ((s % bl) + k) % bl;
    endfunction

    function automatic logic [7:0] dpat(int sq, int e);
        return 8'((sq * 8 + e) * 7 + 3);
    endfunction

    function automatic logic mpat(int sq, int e);
        return ((sq + e) % 3) == 0;
    endfunction

    task automatic idle_checks(input string tag);
        chk({tag, " cmd"}, 64'(cmd), 64'h7);
        chk({tag, " ready"}, 64'(ready), 64'h1);
        chk({tag, " dq_oe"}, 64'(dq_oe), 64'h0);
        chk({tag, " dqs_oe"}, 64'(dqs_oe), 64'h0);
        chk({tag, " dqs_tgl"}, 64'(dqs_tgl), 64'h0);
    endtask

    task automatic run_seq(input int sq, input bit bl8, input bit ilv, input int s,
                           input bit late, input bit poke);
        logic [COL_W-1:0] col, rcol;
        logic [BA_W-1:0]  bank;
        int last, tr, rd_t, e1;
        col  = COL_W'(((sq % 64) << 3) | s);
        rcol = COL_W'(sq * 13 + 1);
        bank = BA_W'(sq % 4);
        last = bl8 ? 2 : 3;
        tr   = late ? last + TW + 4 : last + TW + 1;
        rd_t = late ? tr - 1 : 1;
        e1   = elem(s, 1, bl8, ilv) % 8;
        @(negedge clk);
        cfg_bl8 = bl8; cfg_ilv = ilv; wr_req = 1'b1; wr_bank = bank; wr_col = col;
        for (int e = 0; e < 8; e++) begin
            wr_data[e*8 +: 8] = dpat(sq, e);
            wr_mask[e] = mpat(sq, e);
        end
        rd_req = 1'b0;
        for (int t = 1; t <= tr + 1; t++) begin
            @(negedge clk);
            if (t == 1) begin
                chk("R2 WRITE cmd", 64'(cmd), 64'h4);
                chk("R2 WRITE bank", 64'(ba), 64'(bank));
                chk("R2 WRITE addr", 64'(addr), 64'(col));
                chk("R2 A10 low", 64'(addr[10]), 64'h0);
                chk("R2 preamble oe", 64'(dqs_oe), 64'h1);
                chk("R2 preamble no toggle", 64'(dqs_tgl), 64'h0);
                chk("R2 busy", 64'(ready), 64'h0);
            end else if (t == 2) begin
                chk("R3 cmd NOP", 64'(cmd), 64'h7);
                chk("R3 dq_oe", 64'(dq_oe), 64'h1);
                chk("R3 dqs toggles", 64'(dqs_tgl), 64'h1);
                chk("R3 first beat", 64'(dq_rise), 64'(dpat(sq, s)));
                chk("R3 first mask", 64'(dm_rise), 64'(mpat(sq, s)));
                chk("R4 second beat", 64'(dq_fall), 64'(dpat(sq, e1)));
                chk("R4 second mask", 64'(dm_fall), 64'(mpat(sq, e1)));
            end else if (t == 3 && !bl8) begin
                chk("R5 tail cmd", 64'(cmd), 64'h7);
                chk("R5 tail toggles", 64'(dqs_tgl), 64'h1);
                chk("R5 tail dq_oe", 64'(dq_oe), 64'h1);
                chk("R5 tail dm", 64'({dm_rise, dm_fall}), 64'h3);
                chk("R5 tail data", 64'({dq_rise, dq_fall}), 64'h0);
            end else if (t < tr) begin
                if (t == 3) begin
                    chk("R6 no tail dqs_oe", 64'(dqs_oe), 64'h0);
                    chk("R6 no tail dq_oe", 64'(dq_oe), 64'h0);
                end
                chk("R7 wait NOP", 64'(cmd), 64'h7);
                chk("R7 wait quiet", 64'({dqs_oe, dq_oe}), 64'h0);
                chk("R7 wait busy", 64'(ready), 64'h0);
            end else if (t == tr) begin
                chk(late ? "R9 late READ cycle" : "R7 READ cycle", 64'(cmd), 64'h5);
                chk("R8 READ bank", 64'(ba), 64'(bank));
                chk("R8 READ addr", 64'(addr), 64'(rcol));
            end else begin
                chk("R8 back to NOP", 64'(cmd), 64'h7);
                chk("R8 ready again", 64'(ready), 64'h1);
            end
            // R10: a write request while busy must not disturb the stream
            wr_req  = (poke && t == 1);
            wr_bank = ~bank;
            rd_req  = (t == rd_t);
            rd_col  = rcol;
        end
        rd_req = 1'b0;
        wr_req = 1'b0;
    endtask

    initial begin
        int sq;
        rst_n = 1'b0; cfg_bl8 = 0; cfg_ilv = 0; wr_req = 0; rd_req = 0;
        wr_bank = '0; wr_col = '0; rd_col = '0; wr_data = '0; wr_mask = '0;
        repeat (3) @(negedge clk);
        idle_checks("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_checks("R1 after reset");
        // R10: read request while idle is ignored
        rd_req = 1'b1; rd_col = 10'h155;
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            idle_checks("R10 idle read ignored");
        end
        sq = 0;
        for (int b = 0; b < 2; b++)
            for (int il = 0; il < 2; il++)
                for (int s = 0; s < 8; s++)
                    for (int lt = 0; lt < 2; lt++) begin
                        run_seq(sq, b[0], il[0], s, lt[0], s == 5);
                        sq++;
                    end
        @(negedge clk);
        idle_checks("R1 final idle");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule